// File: doc/BRIEF.md
# Bit Field Read/Write Unit

This unit reads and writes a bit field inside one word of a word-addressed memory. Its operands come from an external operand stack. A command names one of six operations and carries an immediate word offset and an immediate field selector. The unit pops the operands that the operation needs, one per cycle. It then forms the word address as pointer plus offset and fetches that word. A read pushes the field back onto the stack, right-justified and zero-extended. A write merges new data into the field bits only and stores the word back to the same address.

There are three variants of each operation. The plain variants take the offset and the selector from the command. The descriptor variants instead pop one packed word from the stack, with the offset in its high half and the selector in its low half. The code-space read fetches from a second memory space. The swapped write pops its operands in the opposite order. While an operation is in flight, the unit accepts no further command. A one-cycle completion pulse marks the cycle of the last memory-side action.

Top module: `bitfield_rw_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1, and `pop_req`, `push_req`, `mem_rd`, `mem_wr` and `done` are all 0.
- R2: Operation code 0 (plain read) pops a pointer and fetches from the data space (`mem_code`=0) at address pointer + zero-extended `cmd_offset`.
- R3: The selector's upper 4 bits give the starting bit, counted so that bit 0 is the word's most significant bit. Its lower 4 bits give the field width minus one. A read pushes the field right-justified, with all bits above it zero.
- R4: A field that would run past the least significant bit is cut at the word boundary with no error. The read returns only the bits that lie inside the word, and a write fills only those bits.
- R5: Operation code 2 (descriptor read) pops a descriptor and then a pointer. Descriptor bits [15:8] are the offset and bits [7:0] are the selector. The command's immediates have no effect.
- R6: Operation code 1 (code-space read) behaves like code 0, but the fetch has `mem_code`=1 and so returns the code-space word.
- R7: Operation code 3 (write) pops the pointer and then the data, and fetches the word. It stores to the same address a word in which the field holds the data's low-order field-width bits and every other bit is unchanged.
- R8: Operation code 4 (swapped write) pops the data first and the pointer second. Its merge is the same as for code 3.
- R9: Operation code 5 (descriptor write) pops the descriptor, then the pointer, then the data. It takes the offset and selector from the descriptor as in R5.
- R10: For an operation with N pops, the pops occur in the N cycles that follow acceptance. `mem_rd` is high in the next cycle. A read raises `push_req` and `done` one cycle after `mem_rd`. A write raises `mem_wr` and `done` two cycles after `mem_rd`.
- R11: `cmd_ready` is 0 from acceptance until the cycle after `done`. A command offered while the unit is busy, and any command with code 6 or 7, is ignored: it causes no pop, push or memory access.
- R12: At most one of `pop_req`, `push_req`, `mem_rd` and `mem_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Operation code (0..5 valid) |
| cmd_offset | input | 8 | Immediate word offset |
| cmd_sel | input | 8 | Immediate field selector |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| pop_req | output | 1 | Take the top stack word this cycle |
| pop_data | input | 16 | Current top stack word |
| push_req | output | 1 | Push `push_data` this cycle |
| push_data | output | 16 | Extracted field |
| mem_rd | output | 1 | Memory fetch strobe |
| mem_wr | output | 1 | Memory store strobe |
| mem_code | output | 1 | Fetch addresses the code space |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Merged store word |
| mem_rdata | input | 16 | Fetched word, valid the cycle after `mem_rd` |
| done | output | 1 | Operation complete |

## Verification
The checker checks the cycle relations on every cycle:
- only one stack or memory strobe is active at a time;
- a push comes exactly one cycle after a fetch;
- a store comes two cycles after a fetch, at the same address;
- `done` coincides with the final action;
- the ready handshake closes on acceptance and reopens after completion.

Only the bench's scenarios can show the data results:
- the extracted and merged field values, including truncated fields;
- the operand order of each variant;
- the selection of the code space;
- that immediates and commands offered while busy or with an undefined code have no effect.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [2:0] {
        OP_RD      = 3'd0,
        OP_RD_CODE = 3'd1,
        OP_RD_DESC = 3'd2,
        OP_WR      = 3'd3,
        OP_WR_SWAP = 3'd4,
        OP_WR_DESC = 3'd5
    } bfu_op_e;

    typedef enum logic [1:0] {
        ROLE_PTR  = 2'd0,
        ROLE_DATA = 2'd1,
        ROLE_DESC = 2'd2
    } pop_role_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_POP    = 3'd1,
        ST_FETCH  = 3'd2,
        ST_RESULT = 3'd3,
        ST_STORE  = 3'd4
    } bfu_state_e;

    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic op_is_write(input bfu_op_e op);
        return (op == OP_WR) || (op == OP_WR_SWAP) || (op == OP_WR_DESC);
    endfunction

    // number of stack words an operation consumes
    function automatic logic [1:0] op_pops(input bfu_op_e op);
        case (op)
            OP_RD, OP_RD_CODE:                   return 2'd1;
            OP_RD_DESC, OP_WR, OP_WR_SWAP:       return 2'd2;
            OP_WR_DESC:                          return 2'd3;
            default:                             return 2'd1;
        endcase
    endfunction

    // meaning of the idx-th popped word for a given operation
    function automatic pop_role_e op_role(input bfu_op_e op, input logic [1:0] idx);
        case (op)
            OP_RD_DESC: return (idx == 2'd0) ? ROLE_DESC : ROLE_PTR;
            OP_WR:      return (idx == 2'd0) ? ROLE_PTR  : ROLE_DATA;
            OP_WR_SWAP: return (idx == 2'd0) ? ROLE_DATA : ROLE_PTR;
            OP_WR_DESC: return (idx == 2'd0) ? ROLE_DESC :
                               (idx == 2'd1) ? ROLE_PTR  : ROLE_DATA;
            default:    return ROLE_PTR;
        endcase
    endfunction

endpackage

// File: rtl/bfu_field_geom.sv
module bfu_field_geom #(
    parameter int DATA_W = 16,
    localparam int POS_W = $clog2(DATA_W),
    localparam int SEL_W = 2 * POS_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [POS_W-1:0]  shift,
    output logic [DATA_W-1:0] mask
);
    localparam int WW = POS_W + 1;

    logic [POS_W-1:0] start_bit;
    logic [POS_W-1:0] len_m1;
    logic [WW-1:0]    last_bit;
    logic [WW-1:0]    width;

    assign start_bit = sel[SEL_W-1:POS_W];
    assign len_m1    = sel[POS_W-1:0];
    assign last_bit  = {1'b0, start_bit} + {1'b0, len_m1};

    always_comb begin
        if (last_bit > WW'(DATA_W - 1)) begin
            // field cut at the least significant end of the word
            shift = '0;
            width = WW'(DATA_W) - {1'b0, start_bit};
        end else begin
            shift = POS_W'(WW'(DATA_W - 1) - last_bit);
            width = {1'b0, len_m1} + WW'(1);
        end
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (WW'(g) < width);
    end

endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu #(
    parameter int DATA_W = 16,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] data,
    input  logic [POS_W-1:0]  shift,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] extracted,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] placed_mask;
    logic [DATA_W-1:0] placed_data;

    assign placed_mask = mask << shift;
    assign placed_data = (data & mask) << shift;
    assign extracted   = (word >> shift) & mask;
    assign merged      = (word & ~placed_mask) | placed_data;

endmodule

// File: rtl/bitfield_rw_unit.sv
module bitfield_rw_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    localparam int POS_W = $clog2(DATA_W),
    localparam int SEL_W = 2 * POS_W,
    localparam int OFF_W = DATA_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [OFF_W-1:0]  cmd_offset,
    input  logic [SEL_W-1:0]  cmd_sel,
    output logic              cmd_ready,
    output logic              pop_req,
    input  logic [DATA_W-1:0] pop_data,
    output logic              push_req,
    output logic [DATA_W-1:0] push_data,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_code,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done
);

    typedef struct packed {
        bfu_state_e        state;
        bfu_op_e           op;
        logic [1:0]        idx;
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] data;
        logic [OFF_W-1:0]  offset;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] word;
    } regs_t;

    regs_t r_q, r_d;

    logic [POS_W-1:0]  fld_shift;
    logic [DATA_W-1:0] fld_mask;
    logic [DATA_W-1:0] fld_value;
    logic [DATA_W-1:0] fld_merged;

    bfu_field_geom #(.DATA_W(DATA_W)) u_geom (
        .sel   (r_q.sel),
        .shift (fld_shift),
        .mask  (fld_mask)
    );

    bfu_field_alu #(.DATA_W(DATA_W)) u_alu (
        .word      (mem_rdata),
        .data      (r_q.data),
        .shift     (fld_shift),
        .mask      (fld_mask),
        .extracted (fld_value),
        .merged    (fld_merged)
    );

    always_comb begin
        r_d       = r_q;
        cmd_ready = (r_q.state == ST_IDLE);
        pop_req   = 1'b0;
        push_req  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        done      = 1'b0;
        mem_addr  = ADDR_W'(r_q.ptr) + ADDR_W'(r_q.offset);
        mem_code  = (r_q.op == OP_RD_CODE);
        mem_wdata = r_q.word;
        push_data = fld_value;

        case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid && op_is_valid(cmd_op)) begin
                    r_d.op     = bfu_op_e'(cmd_op);
                    r_d.offset = cmd_offset;
                    r_d.sel    = cmd_sel;
                    r_d.idx    = 2'd0;
                    r_d.state  = ST_POP;
                end
            end
            ST_POP: begin
                pop_req = 1'b1;
                case (op_role(r_q.op, r_q.idx))
                    ROLE_PTR:  r_d.ptr  = pop_data;
                    ROLE_DATA: r_d.data = pop_data;
                    ROLE_DESC: begin
                        r_d.offset = pop_data[DATA_W-1:SEL_W];
                        r_d.sel    = pop_data[SEL_W-1:0];
                    end
                    default: ;
                endcase
                if (r_q.idx == op_pops(r_q.op) - 2'd1) begin
                    r_d.state = ST_FETCH;
                end else begin
                    r_d.idx = r_q.idx + 2'd1;
                end
            end
            ST_FETCH: begin
                mem_rd    = 1'b1;
                r_d.state = ST_RESULT;
            end
            ST_RESULT: begin
                if (op_is_write(r_q.op)) begin
                    r_d.word  = fld_merged;
                    r_d.state = ST_STORE;
                end else begin
                    push_req  = 1'b1;
                    done      = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_STORE: begin
                mem_wr    = 1'b1;
                done      = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: OP_RD, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cmd_ready,
    input logic              pop_req,
    input logic              push_req,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_code,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_req, push_req, mem_rd, mem_wr}));

    assert_push_follows_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> $past(mem_rd));

    assert_store_follows_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

    assert_done_on_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (push_req || mem_wr));

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op <= 3'd5) |=> !cmd_ready);

    assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    assert_not_ready_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !cmd_ready);

    assert_code_read_pushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_code) |=> push_req);

endmodule

bind bitfield_rw_unit bfu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .pop_req   (pop_req),
    .push_req  (push_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_code  (mem_code),
    .mem_addr  (mem_addr),
    .done      (done)
);

// File: tb/sim_bitfield_rw_unit.sv
`timescale 1ns/1ps
module sim_bitfield_rw_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_offset = 8'd0;
    logic [7:0]  cmd_sel = 8'd0;
    logic        cmd_ready;
    logic        pop_req;
    logic [15:0] pop_data;
    logic        push_req;
    logic [15:0] push_data;
    logic        mem_rd, mem_wr, mem_code;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic        done;

    always #10 clk = ~clk;

    bitfield_rw_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_offset(cmd_offset), .cmd_sel(cmd_sel), .cmd_ready(cmd_ready),
        .pop_req(pop_req), .pop_data(pop_data), .push_req(push_req),
        .push_data(push_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_code(mem_code), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    // ---- environment models ----
    logic [15:0] data_mem [0:255];
    logic [15:0] code_mem [0:255];
    logic [15:0] stk [0:7];
    int          sp = 0;

    assign pop_data = (sp > 0) ? stk[sp-1] : 16'h0;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_code ? code_mem[mem_addr[7:0]] : data_mem[mem_addr[7:0]];
        if (mem_wr) data_mem[mem_addr[7:0]] <= mem_wdata;
        if (pop_req) sp <= sp - 1;
        if (push_req) begin
            stk[sp] <= push_data;
            sp <= sp + 1;
        end
    end

    // ---- scoreboard ----
    typedef struct packed {
        logic [1:0]  kind;   // 0 fetch, 1 push, 2 store
        logic        code;
        logic [15:0] addr;
        logic [15:0] data;
    } ev_t;

    ev_t   sbq[$];
    string cur_req = "R1";
    int    n_checks = 0;
    int    n_fail = 0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && (mem_rd || push_req || mem_wr)) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R11", "unexpected strobe",
                      {28'd0, mem_rd, push_req, mem_wr, 1'b0}, 32'd0);
            end else begin
                ev_t e;
                e = sbq.pop_front();
                if (mem_rd) begin
                    check(e.kind == 2'd0, cur_req, "fetch order", 32'(e.kind), 32'd0);
                    check(mem_addr == e.addr, cur_req, "fetch addr", 32'(mem_addr), 32'(e.addr));
                    check(mem_code == e.code, cur_req, "fetch space", 32'(mem_code), 32'(e.code));
                end else if (push_req) begin
                    check(e.kind == 2'd1, cur_req, "push order", 32'(e.kind), 32'd1);
                    check(push_data == e.data, cur_req, "field value", 32'(push_data), 32'(e.data));
                end else begin
                    check(e.kind == 2'd2, cur_req, "store order", 32'(e.kind), 32'd2);
                    check(mem_addr == e.addr, cur_req, "store addr", 32'(mem_addr), 32'(e.addr));
                    check(mem_wdata == e.data, cur_req, "merged word", 32'(mem_wdata), 32'(e.data));
                end
            end
        end
    end

    // ---- bench-side field model, bit by bit, bit 0 = MSB ----
    function automatic logic [15:0] m_read(input logic [15:0] w, input logic [7:0] s);
        int first = s[7:4];
        int last = s[7:4] + s[3:0];
        logic [15:0] r = 16'h0;
        if (last > 15) last = 15;
        for (int i = first; i <= last; i++) r = {r[14:0], w[15-i]};
        return r;
    endfunction

    function automatic logic [15:0] m_write(input logic [15:0] w, input logic [15:0] d,
                                            input logic [7:0] s);
        int first = s[7:4];
        int last = s[7:4] + s[3:0];
        logic [15:0] r = w;
        if (last > 15) last = 15;
        for (int i = first; i <= last; i++) r[15-i] = d[last-i];
        return r;
    endfunction

    // ---- driver ----
    task automatic run_op(input logic [2:0] op, input logic [7:0] off, input logic [7:0] sel,
                          input int n, input logic [15:0] p0, input logic [15:0] p1,
                          input logic [15:0] p2, input int hold, input string req);
        logic [15:0] ptr, dat, addr, old;
        logic [7:0]  eoff, esel;
        int k;
        ev_t e;
        eoff = off; esel = sel; ptr = 16'h0; dat = 16'h0;
        case (op)
            3'd0, 3'd1: ptr = p0;
            3'd2: begin eoff = p0[15:8]; esel = p0[7:0]; ptr = p1; end
            3'd3: begin ptr = p0; dat = p1; end
            3'd4: begin dat = p0; ptr = p1; end
            default: begin eoff = p0[15:8]; esel = p0[7:0]; ptr = p1; dat = p2; end
        endcase
        addr = ptr + {8'h0, eoff};
        old = (op == 3'd1) ? code_mem[addr[7:0]] : data_mem[addr[7:0]];

        @(negedge clk);
        cur_req = req;
        if (n >= 3) stk[n-3] = p2;
        if (n >= 2) stk[n-2] = p1;
        stk[n-1] = p0;
        sp = n;
        e = '{kind: 2'd0, code: (op == 3'd1), addr: addr, data: 16'h0};
        sbq.push_back(e);
        if (op <= 3'd2) e = '{kind: 2'd1, code: 1'b0, addr: 16'h0, data: m_read(old, esel)};
        else            e = '{kind: 2'd2, code: 1'b0, addr: addr, data: m_write(old, dat, esel)};
        sbq.push_back(e);
        check(cmd_ready == 1'b1, "R11", "ready before command", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1; cmd_op = op; cmd_offset = off; cmd_sel = sel;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            if (k <= hold) begin
                cmd_op = 3'd0;
                check(cmd_ready == 1'b0, "R11", "ready while busy", 32'(cmd_ready), 32'd0);
            end else begin
                cmd_valid = 1'b0;
            end
            if (done || k > 40) break;
        end
        cmd_valid = 1'b0;
        check(k == n + ((op <= 3'd2) ? 2 : 3), "R10", "cycles to done", 32'(k),
              32'(n + ((op <= 3'd2) ? 2 : 3)));
        @(negedge clk);
        check(cmd_ready == 1'b1, "R11", "ready after done", 32'(cmd_ready), 32'd1);
        check(sbq.size() == 0, req, "pending events", 32'(sbq.size()), 32'd0);
        check(sp == ((op <= 3'd2) ? 1 : 0), req, "stack depth", 32'(sp),
              32'((op <= 3'd2) ? 1 : 0));
        if (op >= 3'd3)
            check(data_mem[addr[7:0]] == m_write(old, dat, esel), req, "memory word",
                  32'(data_mem[addr[7:0]]), 32'(m_write(old, dat, esel)));
        sbq.delete();
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            data_mem[i] = 16'(i * 16'h1357) ^ 16'hA5A5;
            code_mem[i] = 16'(i * 16'h0F1D) ^ 16'h3C96;
        end
        data_mem[8'h13] = 16'hA5C3;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(cmd_ready && !pop_req && !push_req && !mem_rd && !mem_wr && !done, "R1",
              "reset outputs", {27'd0, cmd_ready, pop_req, push_req, mem_rd, mem_wr}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !pop_req && !push_req && !mem_rd && !mem_wr && !done, "R1",
              "after reset", {27'd0, cmd_ready, pop_req, push_req, mem_rd, mem_wr}, 32'h10);

        run_op(3'd0, 8'h03, 8'h47, 1, 16'h0010, 16'h0, 16'h0, 0, "R2");  // middle field
        run_op(3'd0, 8'h00, 8'h0F, 1, 16'h0013, 16'h0, 16'h0, 0, "R3");  // full word
        run_op(3'd0, 8'h02, 8'hF0, 1, 16'h0011, 16'h0, 16'h0, 0, "R3");  // LSB only
        run_op(3'd0, 8'h01, 8'h00, 1, 16'h0020, 16'h0, 16'h0, 0, "R3");  // MSB only
        run_op(3'd0, 8'h05, 8'hC7, 1, 16'h0030, 16'h0, 16'h0, 0, "R4");  // truncated
        run_op(3'd1, 8'h04, 8'h2B, 1, 16'h0013, 16'h0, 16'h0, 0, "R6");  // code space
        run_op(3'd2, 8'hEE, 8'hFF, 2, 16'h0523, 16'h0040, 16'h0, 0, "R5");
        run_op(3'd3, 8'h02, 8'h47, 2, 16'h0050, 16'hFFFF, 16'h0, 0, "R7");
        run_op(3'd3, 8'h00, 8'h35, 2, 16'h0060, 16'h0000, 16'h0, 0, "R7");
        run_op(3'd4, 8'h01, 8'h64, 2, 16'h0013, 16'h0070, 16'h0, 0, "R8");
        run_op(3'd5, 8'hAA, 8'h55, 3, 16'h0391, 16'h0080, 16'hBEEF, 0, "R9");
        run_op(3'd3, 8'h03, 8'hD7, 2, 16'h0090, 16'h0005, 16'h0, 0, "R4");  // truncated write
        run_op(3'd3, 8'h04, 8'h1A, 2, 16'h00A0, 16'h1234, 16'h0, 2, "R11"); // offered while busy

        // R11: undefined code has no effect
        @(negedge clk);
        cur_req = "R11";
        stk[0] = 16'h0042; sp = 1;
        cmd_valid = 1'b1; cmd_op = 3'd7;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sp == 1, "R11", "undefined op pop count", 32'(sp), 32'd1);
        check(cmd_ready == 1'b1, "R11", "undefined op ready", 32'(cmd_ready), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule